// File: doc/BRIEF.md
# Carry-Skip Adder

This block adds two unsigned words and a carry-in, or subtracts one word from the other. The word is split into ripple groups of equal width. Inside each group the carry ripples from bit to bit. Each group also forms a bypass condition, which is true when every bit in the group propagates. When the bypass condition holds, the carry leaving the group is taken straight from the carry entering it, so the carry does not wait on the group's ripple chain.

The worst path with the default shape starts in the lowest group, bypasses the two middle groups and ripples through the top group. A subtract control inverts the second operand and forces the carry into the lowest group to 1. The sum and carry-out are registered on the rising clock edge, so results appear one cycle after the operands are presented. A synchronous active-high reset clears the registered result.

The total width must be a whole multiple of the group width. Any other combination stops elaboration with an error.

Top module: `csk_add`

## Requirements
- R1: With `op_sub`=0, the registered result {`co_q`,`sum_q`} equals `opa`+`opb`+`ci` (unsigned, WIDTH+1 bits) sampled at the previous rising edge.
- R2: Inside a group the carry obeys c(i+1) = (a&b) | ((a^b) & c(i)). A group whose top bit has both operand bits at 1 always passes out a carry of 1. A group whose top bit has both operand bits at 0 always passes out a carry of 0.
- R3: A group's bypass condition is the AND of (a^b) over all of its bits. When it is 1, the group's carry-out equals its carry-in. A fully propagating lower group therefore delivers the incoming carry to the next group.
- R4: With `op_sub`=1, `sum_q` equals `opa`−`opb` modulo 2^WIDTH and `co_q` is 1 exactly when `opa` ≥ `opb`. In this mode `ci` has no effect on the result.
- R5: When the operands are bitwise complements of each other (every bit propagates), the result is all ones with `co_q`=0 for `ci`=0. It is all zeros with `co_q`=1 for `ci`=1.
- R6: While `rst` is 1 at a rising edge, the next values of `sum_q` and `co_q` are 0, whatever the operands are.
- R7: A carry generated in bit 0 with every higher bit propagating (for example 0xFFFF + 0x0001) produces `sum_q`=0 and `co_q`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | WIDTH | First operand (minuend when subtracting) |
| opb | input | WIDTH | Second operand (subtrahend when subtracting) |
| ci | input | 1 | Carry-in, used only when adding |
| op_sub | input | 1 | 1 selects subtraction, 0 selects addition |
| sum_q | output | WIDTH | Registered sum or difference |
| co_q | output | 1 | Registered carry-out (1 means no borrow when subtracting) |

## Verification
The bench builds the adder with WIDTH=16 and GROUP=4. This gives four groups, so a carry entering at bit 0 can be bypassed across two complete inner groups, and the longest skip route is reachable. The directed vectors exercise several paths:
- complementary operand pairs, which force every group into bypass;
- single-group generate and kill cases;
- a carry that is handed from a bypassing group into a killing group;
- subtraction both with and without a borrow.

Random sums and differences are then compared against plain arithmetic on both the add path and the subtract path.

// File: rtl/csk_pkg.sv
package csk_pkg;
  // result leaving one ripple group
  typedef struct packed {
    logic carry;   // carry toward the next group
    logic skip;    // every bit of the group propagates
  } grp_res_t;
endpackage

// File: rtl/csk_pg.sv
module csk_pg #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  // per-bit generate and propagate; kill is the case where neither holds
  genvar i;
  for (i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = x[i] & y[i];
    assign prop[i] = x[i] ^ y[i];
  end
endmodule

// File: rtl/csk_group.sv
module csk_group
  import csk_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] gen,
  input  logic [GW-1:0] prop,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output grp_res_t      res
);
  logic [GW:0] chain;

  assign chain[0] = cin;

  genvar i;
  for (i = 0; i < GW; i++) begin : g_rip
    assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
    assign sum[i]     = prop[i] ^ chain[i];
  end

  // bypass: all bits propagate, so the incoming carry is forwarded unchanged
  assign res.skip  = &prop;
  assign res.carry = res.skip ? cin : chain[GW];
endmodule

// File: rtl/csk_add.sv
module csk_add
  import csk_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             ci,
  input  logic             op_sub,
  output logic [WIDTH-1:0] sum_q,
  output logic             co_q
);
  localparam int NGRP = WIDTH / GROUP;

  if ((WIDTH % GROUP) != 0) begin : g_shape_bad
    $error("csk_add: WIDTH must be a multiple of GROUP");
  end

  logic [WIDTH-1:0] opb_eff;
  logic             c_low;
  logic [WIDTH-1:0] gen, prop, sum_c;
  logic [NGRP:0]    gcar;
  grp_res_t         gres [NGRP];

  // subtraction: invert subtrahend, force the low carry to 1
  assign opb_eff = op_sub ? ~opb : opb;
  assign c_low   = op_sub ? 1'b1 : ci;
  assign gcar[0] = c_low;

  csk_pg #(.WIDTH(WIDTH)) u_pg (
    .x(opa), .y(opb_eff), .gen(gen), .prop(prop)
  );

  genvar g;
  for (g = 0; g < NGRP; g++) begin : g_grp
    csk_group #(.GW(GROUP)) u_grp (
      .gen (gen [g*GROUP +: GROUP]),
      .prop(prop[g*GROUP +: GROUP]),
      .cin (gcar[g]),
      .sum (sum_c[g*GROUP +: GROUP]),
      .res (gres[g])
    );
    assign gcar[g+1] = gres[g].carry;

    AST_SKIP_FORWARD: assert property (@(posedge clk) disable iff (rst)
      gres[g].skip |-> (gcar[g+1] == gcar[g]));                          // R3
    AST_TOP_GENERATE: assert property (@(posedge clk) disable iff (rst)
      gen[g*GROUP+GROUP-1] |-> gcar[g+1]);                               // R2
    AST_TOP_KILL: assert property (@(posedge clk) disable iff (rst)
      !(gen[g*GROUP+GROUP-1] | prop[g*GROUP+GROUP-1]) |-> !gcar[g+1]);   // R2
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      co_q  <= 1'b0;
    end else begin
      sum_q <= sum_c;
      co_q  <= gcar[NGRP];
    end
  end

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !op_sub |=> ({co_q, sum_q} == $past({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, ci}))); // R1
  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
    op_sub |=> ((sum_q == $past(opa - opb)) && (co_q == $past(opa >= opb))));              // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> ((sum_q == '0) && !co_q));                                                     // R6
endmodule

// File: tb/sim_csk_add.sv
module sim_csk_add;
  localparam int W = 16;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0;
  logic         ci = 1'b0, op_sub = 1'b0;
  logic [W-1:0] sum_q;
  logic         co_q;
  int           checks = 0, errors = 0;
  bit           done = 0;

  always #10ns clk = ~clk;

  csk_add #(.WIDTH(16), .GROUP(4)) u0 (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .ci(ci),
    .op_sub(op_sub), .sum_q(sum_q), .co_q(co_q)
  );

  // {op_sub, ci, opa, opb, expected carry, expected sum}
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h1234, 16'h4321, 1'b0, 16'h5555},  // R1 plain sum
    {1'b0, 1'b0, 16'hFFFF, 16'h0001, 1'b1, 16'h0000},  // R7 long carry
    {1'b0, 1'b1, 16'hA5A5, 16'h5A5A, 1'b1, 16'h0000},  // R5 all skip, ci=1
    {1'b0, 1'b0, 16'hA5A5, 16'h5A5A, 1'b0, 16'hFFFF},  // R5 all skip, ci=0
    {1'b0, 1'b1, 16'h0F0F, 16'hF0F0, 1'b1, 16'h0000},  // R5 other pattern
    {1'b0, 1'b0, 16'h8000, 16'h8000, 1'b1, 16'h0000},  // R2 top generate
    {1'b0, 1'b0, 16'h00FF, 16'h0F01, 1'b0, 16'h1000},  // R2 internal ripple
    {1'b0, 1'b1, 16'h000F, 16'h0000, 1'b0, 16'h0010},  // R3 skip into kill
    {1'b1, 1'b0, 16'h5000, 16'h1234, 1'b1, 16'h3DCC},  // R4 no borrow
    {1'b1, 1'b0, 16'h0001, 16'h0002, 1'b0, 16'hFFFF},  // R4 borrow
    {1'b1, 1'b1, 16'h0001, 16'h0002, 1'b0, 16'hFFFF},  // R4 ci ignored
    {1'b1, 1'b0, 16'h1234, 16'h1234, 1'b1, 16'h0000},  // R4 equal operands
    {1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 16'h0001}   // R1 carry-in only
  };

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic c, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    op_sub = s; ci = c; opa = x; opb = y;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R6: reset held with busy operands
    drive(1'b0, 1'b1, 16'hFFFF, 16'hFFFF);
    check("R6 reset hold", {co_q, sum_q}, 17'h0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][50], VEC[k][49], VEC[k][48:33], VEC[k][32:17]);
      check($sformatf("R1-R7 vector %0d", k), {co_q, sum_q}, VEC[k][16:0]);
    end

    for (int k = 0; k < 150; k++) begin
      logic [W-1:0] x, y;
      logic c;
      x = W'($urandom); y = W'($urandom); c = 1'($urandom);
      drive(1'b0, c, x, y);
      check("R1 random add", {co_q, sum_q}, {1'b0, x} + {1'b0, y} + {16'h0, c});
      drive(1'b1, c, x, y);
      check("R4 random sub", {co_q, sum_q}, {(x >= y), W'(x - y)});
    end

    // R5 with random complementary pairs
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] x;
      x = W'($urandom);
      drive(1'b0, 1'b1, x, ~x);
      check("R5 complement ci=1", {co_q, sum_q}, 17'h10000);
      drive(1'b0, 1'b0, x, ~x);
      check("R5 complement ci=0", {co_q, sum_q}, 17'h0FFFF);
    end

    // R6: reset asserted mid-run
    @(negedge clk);
    rst = 1'b1; op_sub = 1'b0; ci = 1'b1; opa = 16'h1111; opb = 16'h2222;
    @(negedge clk);
    check("R6 reset mid-run", {co_q, sum_q}, 17'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {co_q, sum_q}, 17'h03334);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule